// File: doc/BRIEF.md
# NAND Command Front End with Area Pointers

This block is the device-side command and address front end of a small-page NAND memory. Bytes on an 8-bit bus are taken in at the cycle where the write strobe is high. With the command latch high the byte is a command. With the address latch high it is an address byte. With both low it is a data byte. The column is not a flat counter. A read-pointer command picks one of three areas: the low half of the main page, the high half, or the 16-byte spare area. One address byte then gives the offset inside that area, and the chosen area stays in force until another pointer command or a reset.

The cell array and the page register sit outside the block. Page read, page program and block erase appear as a request held toward an external array port until that port reports done. Program data bytes are forwarded one per cycle with their page column. The block returns identification and status bytes on read strobes. It also drives an active-high ready line that mimics an open-drain ready/busy pin.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset the ready line is high, busOut is 00h, no array request is pending, and the block is in read mode with the low-half area selected.
- R2: Pointer command 00h gives a start column of the column byte, 01h gives 256 plus the column byte, and 50h gives 512 plus the low four bits of the column byte. The start column appears on arrCol while a read or program request is pending.
- R3: A selected area and read mode persist: after a read completes, four further address bytes with no new command start another read in the same area. Reset restores the low-half area.
- R4: In read mode the fourth address byte starts a read. From the next cycle arrReq is high, arrOp is 0, arrRow is {byte4,byte3,byte2}, and ready is low, all held until arrDone is seen.
- R5: Erase needs 60h, three address bytes and then D0h. This gives arrOp 2, arrRow {byte3,byte2,byte1} and arrCol 0. D0h without a complete setup, or after an intervening command, starts nothing.
- R6: After 80h and four address bytes, each data byte gives one pgWrEn pulse on the next cycle, with pgData and a pgCol that starts at the R2 start column and counts up. Bytes that would land at column 528 or above are dropped. 10h then starts a request with arrOp 1.
- R7: 90h followed by address byte 00h makes successive read strobes return ECh, then 76h, then 00h. Any other address byte after 90h leaves read strobes returning 00h.
- R8: After 70h each read strobe returns the status byte. Bit 7 is wrProtN, bit 6 is the ready line at the strobe, and bit 0 is arrFail latched at the done of the last program or erase; reads leave bit 0 unchanged. All other bits are 0.
- R9: Reset command FFh is accepted at any time. It drops any array request and holds ready low for exactly RST_CYCLES cycles, even when it is issued while ready.
- R10: While ready is low, commands other than 70h and FFh, address bytes and data bytes have no effect on any later output.
- R11: A read strobe with neither status nor ID output selected returns 00h, and busOut changes only at a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Write strobe, one cycle per byte |
| cmdLatch | input | 1 | Byte is a command |
| addrLatch | input | 1 | Byte is an address byte |
| rdStb | input | 1 | Read strobe for ID or status bytes |
| busIn | input | 8 | Byte written by the host |
| wrProtN | input | 1 | Write-protect level reported in status bit 7 |
| busOut | output | 8 | Byte returned on read strobes |
| rdyBsy | output | 1 | High when ready, low when busy |
| arrReq | output | 1 | Array operation pending |
| arrOp | output | 2 | 0 read, 1 program, 2 erase |
| arrRow | output | ROW_W | Row address of the operation |
| arrCol | output | COL_W | Start column of the operation |
| arrDone | input | 1 | Array finished the pending operation |
| arrFail | input | 1 | Result of the finished operation, sampled with arrDone |
| pgWrEn | output | 1 | One program data byte valid |
| pgCol | output | COL_W | Page column of that byte |
| pgData | output | 8 | Program data byte |

## Verification
The assertions assume that at most one of the command and address latches is high together with a write strobe. They also assume that arrDone comes only while a request is pending, and that a read strobe never falls in the same cycle as a command that changes the output selection. The stimulus drives one host byte at a time between clock edges and always leaves a gap cycle between a command and a read strobe. It raises arrDone only after the request has been visible for some cycles. Reset is exercised both from ready and in the middle of a pending read, which covers the only path that withdraws a request without done.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } arrOp_e;

  typedef enum logic [1:0] {
    AREA_A = 2'd0,
    AREA_B = 2'd1,
    AREA_C = 2'd2
  } area_e;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ID     = 2'd2
  } outSel_e;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_READ   = 3'd1,
    M_PROG   = 3'd2,
    M_ERASE  = 3'd3,
    M_IDADDR = 3'd4
  } mode_e;

  localparam logic [7:0] CMD_PTR_LO   = 8'h00;
  localparam logic [7:0] CMD_PTR_HI   = 8'h01;
  localparam logic [7:0] CMD_PTR_SP   = 8'h50;
  localparam logic [7:0] CMD_PROG_SET = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE_SET = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    areaLoad;
    area_e   area;
    logic    addrWr;
    logic [2:0] addrIdx;
    logic    colLoad;
    logic    dataWr;
    logic    selLoad;
    outSel_e sel;
    arrOp_e  op;
  } ctrlStrb_t;

endpackage

// File: rtl/nand_front_ctrl.sv
module nand_front_ctrl
  import nand_front_pkg::*;
#(
  parameter int ROW_BYTES  = 3,
  parameter int RST_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       cmdLatch,
  input  logic       addrLatch,
  input  logic [7:0] busIn,
  input  logic       arrDone,
  input  logic       arrFail,
  output ctrlStrb_t  strb,
  output logic       busy,
  output logic       fail,
  output logic       arrReq,
  output arrOp_e     arrOp
);

  localparam int RST_W     = $clog2(RST_CYCLES + 1);
  localparam int RD_CYCLES = ROW_BYTES + 1;
  localparam logic [2:0] LAST_RD = 3'(RD_CYCLES - 1);
  localparam logic [2:0] FULL_RD = 3'(RD_CYCLES);
  localparam logic [2:0] FULL_ER = 3'(ROW_BYTES);

  mode_e            mode;
  logic [2:0]       addrCnt;
  logic             opBusy;
  arrOp_e           opQ;
  logic [RST_W-1:0] rstCnt;
  logic             failQ;

  logic cmdEv, adrEv, datEv;
  logic cmdOk, adrOk, datOk;
  logic isPtr, isReset;
  logic startRead, startProg, startErase;

  assign busy  = opBusy | (rstCnt != '0);
  assign fail  = failQ;
  assign arrReq = opBusy;
  assign arrOp  = opQ;

  assign cmdEv = wrStb & cmdLatch & ~addrLatch;
  assign adrEv = wrStb & addrLatch & ~cmdLatch;
  assign datEv = wrStb & ~cmdLatch & ~addrLatch;

  assign cmdOk = cmdEv & (~busy | (busIn == CMD_RESET) | (busIn == CMD_STATUS));
  assign adrOk = adrEv & ~busy;
  assign datOk = datEv & ~busy & (mode == M_PROG) & (addrCnt == FULL_RD);

  assign isPtr   = (busIn == CMD_PTR_LO) | (busIn == CMD_PTR_HI) | (busIn == CMD_PTR_SP);
  assign isReset = cmdOk & (busIn == CMD_RESET);

  assign startRead  = adrOk & (mode == M_READ) & (addrCnt == LAST_RD);
  assign startProg  = cmdOk & (busIn == CMD_PROG_GO) & (mode == M_PROG) & (addrCnt == FULL_RD);
  assign startErase = cmdOk & (busIn == CMD_ERASE_GO) & (mode == M_ERASE) & (addrCnt == FULL_ER);

  // Strobes toward the datapath
  always_comb begin
    strb          = '0;
    strb.op       = opQ;
    strb.areaLoad = cmdOk & (isPtr | isReset);
    unique case (busIn)
      CMD_PTR_HI: strb.area = AREA_B;
      CMD_PTR_SP: strb.area = AREA_C;
      default:    strb.area = AREA_A;
    endcase
    strb.addrWr  = adrOk & ((mode == M_READ) |
                            ((mode == M_PROG) & (addrCnt != FULL_RD)) |
                            ((mode == M_ERASE) & (addrCnt != FULL_ER)));
    strb.addrIdx = addrCnt;
    strb.colLoad = adrOk & (mode == M_PROG) & (addrCnt == LAST_RD);
    strb.dataWr  = datOk;
    if (cmdOk) begin
      strb.selLoad = 1'b1;
      strb.sel     = (busIn == CMD_STATUS) ? SEL_STATUS : SEL_NONE;
    end else if (adrOk & (mode == M_IDADDR) & (busIn == 8'h00)) begin
      strb.selLoad = 1'b1;
      strb.sel     = SEL_ID;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= M_READ;
      addrCnt <= '0;
      opBusy  <= 1'b0;
      opQ     <= OP_READ;
      rstCnt  <= '0;
      failQ   <= 1'b0;
    end else begin
      if (rstCnt != '0) rstCnt <= rstCnt - 1'b1;

      if (opBusy && arrDone) begin
        opBusy <= 1'b0;
        if (opQ != OP_READ) failQ <= arrFail;
      end

      if (cmdOk) begin
        unique case (busIn)
          CMD_PTR_LO, CMD_PTR_HI, CMD_PTR_SP: begin
            mode    <= M_READ;
            addrCnt <= '0;
          end
          CMD_PROG_SET: begin
            mode    <= M_PROG;
            addrCnt <= '0;
          end
          CMD_ERASE_SET: begin
            mode    <= M_ERASE;
            addrCnt <= '0;
          end
          CMD_IDENT: begin
            mode    <= M_IDADDR;
            addrCnt <= '0;
          end
          CMD_STATUS: ;
          CMD_RESET: begin
            rstCnt  <= RST_W'(RST_CYCLES);
            opBusy  <= 1'b0;
            mode    <= M_READ;
            addrCnt <= '0;
          end
          default: begin
            mode    <= M_IDLE;
            addrCnt <= '0;
          end
        endcase
        if (startProg) begin
          opBusy <= 1'b1;
          opQ    <= OP_PROG;
        end
        if (startErase) begin
          opBusy <= 1'b1;
          opQ    <= OP_ERASE;
        end
      end

      if (adrOk) begin
        unique case (mode)
          M_READ: begin
            if (startRead) begin
              addrCnt <= '0;
              opBusy  <= 1'b1;
              opQ     <= OP_READ;
            end else begin
              addrCnt <= addrCnt + 1'b1;
            end
          end
          M_PROG:   if (addrCnt != FULL_RD) addrCnt <= addrCnt + 1'b1;
          M_ERASE:  if (addrCnt != FULL_ER) addrCnt <= addrCnt + 1'b1;
          M_IDADDR: mode <= M_IDLE;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/nand_front_dpath.sv
module nand_front_dpath
  import nand_front_pkg::*;
#(
  parameter int         MAIN_BYTES  = 512,
  parameter int         SPARE_BYTES = 16,
  parameter int         ROW_BYTES   = 3,
  parameter int         COL_W       = 10,
  parameter int         ROW_W       = 24,
  parameter logic [7:0] MAKER_ID    = 8'hEC,
  parameter logic [7:0] DEVICE_ID   = 8'h76
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             rdStb,
  input  logic [7:0]       busIn,
  input  logic             busy,
  input  logic             fail,
  input  logic             wrProtN,
  output logic [7:0]       busOut,
  output logic [ROW_W-1:0] arrRow,
  output logic [COL_W-1:0] arrCol,
  output logic             pgWrEn,
  output logic [COL_W-1:0] pgCol,
  output logic [7:0]       pgData
);

  localparam int NBYTES     = ROW_BYTES + 1;
  localparam int HALF       = MAIN_BYTES / 2;
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam logic [7:0]       SPARE_MASK = 8'(SPARE_BYTES - 1);
  localparam logic [COL_W-1:0] BASE_B     = COL_W'(HALF);
  localparam logic [COL_W-1:0] BASE_C     = COL_W'(MAIN_BYTES);
  localparam logic [COL_W-1:0] PAGE_END   = COL_W'(PAGE_BYTES);

  area_e            area;
  logic [7:0]       addrB [NBYTES];
  logic [COL_W-1:0] startCol;
  logic [COL_W-1:0] colPtr;
  outSel_e          sel;
  logic [1:0]       idIdx;
  logic [ROW_W-1:0] rowRd, rowEr;

  // Address byte store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NBYTES; i++) addrB[i] <= 8'h00;
    end else if (strb.addrWr) begin
      for (int i = 0; i < NBYTES; i++)
        if (strb.addrIdx == 3'(i)) addrB[i] <= busIn;
    end
  end

  // Row assembly: reads and programs skip the column byte, erase does not
  for (genvar k = 0; k < ROW_BYTES; k++) begin : g_row
    assign rowRd[k*8 +: 8] = addrB[k+1];
    assign rowEr[k*8 +: 8] = addrB[k];
  end

  always_comb begin
    unique case (area)
      AREA_B:  startCol = BASE_B + COL_W'(addrB[0]);
      AREA_C:  startCol = BASE_C + COL_W'(addrB[0] & SPARE_MASK);
      default: startCol = COL_W'(addrB[0]);
    endcase
  end

  assign arrRow = (strb.op == OP_ERASE) ? rowEr : rowRd;
  assign arrCol = (strb.op == OP_ERASE) ? '0 : startCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) area <= AREA_A;
    else if (strb.areaLoad) area <= strb.area;
  end

  // Program data forwarding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colPtr <= '0;
      pgWrEn <= 1'b0;
      pgCol  <= '0;
      pgData <= 8'h00;
    end else begin
      pgWrEn <= 1'b0;
      if (strb.colLoad) begin
        colPtr <= startCol;
      end else if (strb.dataWr && (colPtr < PAGE_END)) begin
        pgWrEn <= 1'b1;
        pgCol  <= colPtr;
        pgData <= busIn;
        colPtr <= colPtr + 1'b1;
      end
    end
  end

  // Read-strobe output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel    <= SEL_NONE;
      idIdx  <= '0;
      busOut <= 8'h00;
    end else begin
      if (strb.selLoad) begin
        sel <= strb.sel;
        if (strb.sel == SEL_ID) idIdx <= '0;
      end
      if (rdStb) begin
        unique case (sel)
          SEL_STATUS: busOut <= {wrProtN, ~busy, 5'b00000, fail};
          SEL_ID: begin
            unique case (idIdx)
              2'd0:    busOut <= MAKER_ID;
              2'd1:    busOut <= DEVICE_ID;
              default: busOut <= 8'h00;
            endcase
            if (idIdx != 2'd2) idIdx <= idIdx + 1'b1;
          end
          default: busOut <= 8'h00;
        endcase
      end
    end
  end

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_front_pkg::*;
#(
  parameter int         MAIN_BYTES  = 512,
  parameter int         SPARE_BYTES = 16,
  parameter int         ROW_BYTES   = 3,
  parameter int         RST_CYCLES  = 500,
  parameter logic [7:0] MAKER_ID    = 8'hEC,
  parameter logic [7:0] DEVICE_ID   = 8'h76,
  localparam int        PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES,
  localparam int        COL_W       = $clog2(PAGE_BYTES + 1),
  localparam int        ROW_W       = ROW_BYTES * 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic             cmdLatch,
  input  logic             addrLatch,
  input  logic             rdStb,
  input  logic [7:0]       busIn,
  input  logic             wrProtN,
  output logic [7:0]       busOut,
  output logic             rdyBsy,
  output logic             arrReq,
  output logic [1:0]       arrOp,
  output logic [ROW_W-1:0] arrRow,
  output logic [COL_W-1:0] arrCol,
  input  logic             arrDone,
  input  logic             arrFail,
  output logic             pgWrEn,
  output logic [COL_W-1:0] pgCol,
  output logic [7:0]       pgData
);

  ctrlStrb_t strb;
  logic      busy;
  logic      fail;
  arrOp_e    opQ;

  nand_front_ctrl #(
    .ROW_BYTES  (ROW_BYTES),
    .RST_CYCLES (RST_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .cmdLatch  (cmdLatch),
    .addrLatch (addrLatch),
    .busIn     (busIn),
    .arrDone   (arrDone),
    .arrFail   (arrFail),
    .strb      (strb),
    .busy      (busy),
    .fail      (fail),
    .arrReq    (arrReq),
    .arrOp     (opQ)
  );

  nand_front_dpath #(
    .MAIN_BYTES  (MAIN_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .ROW_BYTES   (ROW_BYTES),
    .COL_W       (COL_W),
    .ROW_W       (ROW_W),
    .MAKER_ID    (MAKER_ID),
    .DEVICE_ID   (DEVICE_ID)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdStb   (rdStb),
    .busIn   (busIn),
    .busy    (busy),
    .fail    (fail),
    .wrProtN (wrProtN),
    .busOut  (busOut),
    .arrRow  (arrRow),
    .arrCol  (arrCol),
    .pgWrEn  (pgWrEn),
    .pgCol   (pgCol),
    .pgData  (pgData)
  );

  assign rdyBsy = ~busy;
  assign arrOp  = opQ;

endmodule

// File: rtl/nand_front_chk.sv
module nand_front_chk #(
  parameter int PAGE_BYTES = 528,
  parameter int COL_W      = 10,
  parameter int ROW_W      = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrStb,
  input logic             cmdLatch,
  input logic             addrLatch,
  input logic             rdStb,
  input logic [7:0]       busIn,
  input logic [7:0]       busOut,
  input logic             rdyBsy,
  input logic             arrReq,
  input logic [1:0]       arrOp,
  input logic [ROW_W-1:0] arrRow,
  input logic [COL_W-1:0] arrCol,
  input logic             arrDone,
  input logic             pgWrEn,
  input logic [COL_W-1:0] pgCol
);

  logic resetCmd;
  assign resetCmd = wrStb && cmdLatch && !addrLatch && (busIn == 8'hFF);

  // R4: a pending request always shows as busy
  a_r4_req_is_busy: assert property (@(posedge clk) disable iff (!rstN)
    arrReq |-> !rdyBsy);

  // R4: request and its fields hold until done or reset
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (arrReq && !arrDone && !resetCmd) |=>
      (arrReq && $stable(arrOp) && $stable(arrRow) && $stable(arrCol)));

  // R9: reset command withdraws the request and shows busy
  a_r9_reset_busy: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> (!arrReq && !rdyBsy));

  // R10: nothing starts while the reset wait is running
  a_r10_no_start_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBsy && !arrReq) |=> !arrReq);

  // R5: a request only rises after a host write
  a_r5_req_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arrReq) |-> $past(wrStb));

  // R6: forwarded program bytes stay inside the page
  a_r6_col_in_page: assert property (@(posedge clk) disable iff (!rstN)
    pgWrEn |-> (pgCol < COL_W'(PAGE_BYTES)));

  // R11: output byte only moves on a read strobe
  a_r11_out_holds: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(busOut));

endmodule

bind nand_cmd_front nand_front_chk #(
  .PAGE_BYTES (PAGE_BYTES),
  .COL_W      (COL_W),
  .ROW_W      (ROW_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrStb     (wrStb),
  .cmdLatch  (cmdLatch),
  .addrLatch (addrLatch),
  .rdStb     (rdStb),
  .busIn     (busIn),
  .busOut    (busOut),
  .rdyBsy    (rdyBsy),
  .arrReq    (arrReq),
  .arrOp     (arrOp),
  .arrRow    (arrRow),
  .arrCol    (arrCol),
  .arrDone   (arrDone),
  .pgWrEn    (pgWrEn),
  .pgCol     (pgCol)
);

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0, cmdLatch = 1'b0, addrLatch = 1'b0, rdStb = 1'b0;
  logic [7:0]  busIn = 8'h00;
  logic        wrProtN = 1'b1;
  logic        arrDone = 1'b0, arrFail = 1'b0;
  logic [7:0]  busOut;
  logic        rdyBsy, arrReq, pgWrEn;
  logic [1:0]  arrOp;
  logic [23:0] arrRow;
  logic [9:0]  arrCol, pgCol;
  logic [7:0]  pgData;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  nand_cmd_front #(.RST_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .cmdLatch(cmdLatch),
    .addrLatch(addrLatch), .rdStb(rdStb), .busIn(busIn), .wrProtN(wrProtN),
    .busOut(busOut), .rdyBsy(rdyBsy), .arrReq(arrReq), .arrOp(arrOp),
    .arrRow(arrRow), .arrCol(arrCol), .arrDone(arrDone), .arrFail(arrFail),
    .pgWrEn(pgWrEn), .pgCol(pgCol), .pgData(pgData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int         mMode = 1;   // 0 idle, 1 read, 2 prog, 3 erase, 4 id-address
  int         mArea = 0;
  logic [7:0] mAddr [$];
  bit         mReq = 0;
  int         mOp = 0;
  int         mRow = 0;
  int         mCol = 0;
  int         mRst = 0;
  bit         mFail = 0;
  int         mSel = 0;    // 0 none, 1 status, 2 id
  int         mIdPos = 0;
  logic [7:0] mOut = 8'h00;
  int         mPtr = 0;
  bit         mPgEn = 0;
  int         mPgCol = 0;
  logic [7:0] mPgData = 8'h00;

  function automatic int colOf(logic [7:0] b);
    if (mArea == 1) return 256 + b;
    if (mArea == 2) return 512 + (b & 8'h0F);
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelCmd(input logic [7:0] b);
    if (b != 8'h70) mSel = 0;
    case (b)
      8'h00, 8'h01, 8'h50: begin
        mArea = (b == 8'h00) ? 0 : (b == 8'h01) ? 1 : 2;
        mMode = 1; mAddr.delete();
      end
      8'h80: begin mMode = 2; mAddr.delete(); end
      8'h60: begin mMode = 3; mAddr.delete(); end
      8'h90: begin mMode = 4; mAddr.delete(); end
      8'h70: mSel = 1;
      8'hFF: begin
        mRst = RST_CYC; mReq = 0; mMode = 1; mArea = 0; mAddr.delete();
      end
      8'h10: begin
        if (mMode == 2 && mAddr.size() == 4) begin
          mReq = 1; mOp = 1;
          mRow = {mAddr[3], mAddr[2], mAddr[1]};
          mCol = colOf(mAddr[0]);
        end
        mMode = 0; mAddr.delete();
      end
      8'hD0: begin
        if (mMode == 3 && mAddr.size() == 3) begin
          mReq = 1; mOp = 2;
          mRow = {mAddr[2], mAddr[1], mAddr[0]};
          mCol = 0;
        end
        mMode = 0; mAddr.delete();
      end
      default: begin mMode = 0; mAddr.delete(); end
    endcase
  endtask

  task automatic modelAddr(input logic [7:0] b);
    case (mMode)
      1: begin
        mAddr.push_back(b);
        if (mAddr.size() == 4) begin
          mReq = 1; mOp = 0;
          mRow = {mAddr[3], mAddr[2], mAddr[1]};
          mCol = colOf(mAddr[0]);
          mAddr.delete();
        end
      end
      2: if (mAddr.size() < 4) begin
        mAddr.push_back(b);
        if (mAddr.size() == 4) mPtr = colOf(mAddr[0]);
      end
      3: if (mAddr.size() < 3) mAddr.push_back(b);
      4: begin
        if (b == 8'h00) begin mSel = 2; mIdPos = 0; end
        mMode = 0;
      end
      default: ;
    endcase
  endtask

  task automatic tick();
    bit busyNow;
    @(posedge clk);
    busyNow = mReq || (mRst > 0);
    mPgEn = 0;
    if (mRst > 0) mRst--;
    if (arrDone && mReq) begin
      mReq = 0;
      if (mOp != 0) mFail = arrFail;
    end
    if (rdStb) begin
      if (mSel == 1) mOut = {wrProtN, !busyNow, 5'b00000, mFail};
      else if (mSel == 2) begin
        mOut = (mIdPos == 0) ? 8'hEC : (mIdPos == 1) ? 8'h76 : 8'h00;
        mIdPos++;
      end else mOut = 8'h00;
    end
    if (wrStb && cmdLatch && !addrLatch) begin
      if (!busyNow || busIn == 8'hFF || busIn == 8'h70) modelCmd(busIn);
    end else if (wrStb && addrLatch && !cmdLatch) begin
      if (!busyNow) modelAddr(busIn);
    end else if (wrStb && !busyNow && mMode == 2 && mAddr.size() == 4 && mPtr < 528) begin
      mPgEn = 1; mPgCol = mPtr; mPgData = busIn; mPtr++;
    end
    @(negedge clk);
    check(rdyBsy === !(mReq || mRst > 0), curReq, rdyBsy, !(mReq || mRst > 0));
    check(arrReq === mReq, curReq, arrReq, mReq);
    check(busOut === mOut, curReq, busOut, mOut);
    check(pgWrEn === mPgEn, curReq, pgWrEn, mPgEn);
    if (mReq) begin
      check(arrOp === 2'(mOp), curReq, arrOp, mOp);
      check(arrRow === 24'(mRow), curReq, arrRow, mRow);
      check(arrCol === 10'(mCol), curReq, arrCol, mCol);
    end
    if (mPgEn) begin
      check(pgCol === 10'(mPgCol), curReq, pgCol, mPgCol);
      check(pgData === mPgData, curReq, pgData, mPgData);
    end
  endtask

  task automatic wr(input bit c, input bit a, input logic [7:0] b);
    wrStb = 1'b1; cmdLatch = c; addrLatch = a; busIn = b;
    tick();
    wrStb = 1'b0; cmdLatch = 1'b0; addrLatch = 1'b0; busIn = 8'h00;
  endtask

  task automatic cmd(input logic [7:0] b);  wr(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  wr(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b);  wr(1'b0, 1'b0, b); endtask

  task automatic rd();
    rdStb = 1'b1; tick(); rdStb = 1'b0;
  endtask

  task automatic done(input bit f);
    repeat (3) tick();
    arrDone = 1'b1; arrFail = f; tick();
    arrDone = 1'b0; arrFail = 1'b0;
  endtask

  task automatic addr4(input logic [7:0] c, input logic [7:0] r0,
                       input logic [7:0] r1, input logic [7:0] r2);
    adr(c); adr(r0); adr(r1); adr(r2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lowCnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    check(rdyBsy === 1'b1, "R1", rdyBsy, 1);
    check(busOut === 8'h00, "R1", busOut, 0);
    check(arrReq === 1'b0, "R1", arrReq, 0);
    tick();

    // R1/R4: power-up read mode, area A, no command needed
    curReq = "R4";
    addr4(8'h12, 8'h34, 8'h56, 8'h01);
    check(arrReq === 1'b1 && arrOp === 2'd0, "R4", arrOp, 0);
    check(arrRow === 24'h015634, "R4", arrRow, 24'h015634);
    check(arrCol === 10'h012, "R1", arrCol, 10'h012);
    check(rdyBsy === 1'b0, "R4", rdyBsy, 0);
    done(1'b0);

    // R2: high half
    curReq = "R2";
    cmd(8'h01);
    addr4(8'h05, 8'h00, 8'h00, 8'h00);
    check(arrCol === 10'd261, "R2", arrCol, 261);
    done(1'b0);
    // R3: pointer persists, no command
    curReq = "R3";
    addr4(8'h07, 8'h11, 8'h00, 8'h00);
    check(arrReq === 1'b1 && arrCol === 10'd263, "R3", arrCol, 263);
    done(1'b0);
    // R2: spare area uses low four bits
    curReq = "R2";
    cmd(8'h50);
    addr4(8'h23, 8'h02, 8'h00, 8'h00);
    check(arrCol === 10'd515, "R2", arrCol, 515);
    done(1'b0);

    // R8: status while ready, with and without write protect
    curReq = "R8";
    cmd(8'h70); tick(); rd();
    check(busOut === 8'hC0, "R8", busOut, 8'hC0);
    wrProtN = 1'b0; tick(); rd();
    check(busOut === 8'h40, "R8", busOut, 8'h40);
    wrProtN = 1'b1;

    // R8/R10: status while busy, ignored commands while busy
    curReq = "R10";
    cmd(8'h00);
    addr4(8'h00, 8'h01, 8'h00, 8'h00);
    cmd(8'h70); tick(); rd();
    check(busOut === 8'h80, "R8", busOut, 8'h80);
    cmd(8'h90); adr(8'h00); cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'hD0);
    done(1'b0);
    tick();
    check(arrReq === 1'b0, "R10", arrReq, 0);
    rd();
    check(busOut === 8'hC0, "R10", busOut, 8'hC0);

    // R7: ID sequence
    curReq = "R7";
    cmd(8'h90); adr(8'h00); tick();
    rd(); check(busOut === 8'hEC, "R7", busOut, 8'hEC);
    rd(); check(busOut === 8'h76, "R7", busOut, 8'h76);
    rd(); check(busOut === 8'h00, "R7", busOut, 0);
    cmd(8'h90); adr(8'h05); tick();
    rd(); check(busOut === 8'h00, "R7", busOut, 0);
    // R11: nothing selected
    curReq = "R11";
    cmd(8'h00); tick(); rd();
    check(busOut === 8'h00, "R11", busOut, 0);

    // R5: proper erase, failing result
    curReq = "R5";
    cmd(8'h60); adr(8'hA0); adr(8'hB1); adr(8'h01); cmd(8'hD0);
    check(arrReq === 1'b1 && arrOp === 2'd2, "R5", arrOp, 2);
    check(arrRow === 24'h01B1A0 && arrCol === 10'd0, "R5", arrRow, 24'h01B1A0);
    done(1'b1);
    cmd(8'h70); tick(); rd();
    check(busOut === 8'hC1, "R8", busOut, 8'hC1);
    // R5: incomplete setup, intervening command, bare confirm
    curReq = "R5";
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0); tick();
    check(arrReq === 1'b0, "R5", arrReq, 0);
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h01); cmd(8'hD0); tick();
    check(arrReq === 1'b0, "R5", arrReq, 0);
    cmd(8'hD0); tick();
    check(arrReq === 1'b0, "R5", arrReq, 0);

    // R6: program in spare area, overflow past the page end dropped
    curReq = "R6";
    cmd(8'h50); cmd(8'h80);
    addr4(8'h0E, 8'h40, 8'h00, 8'h00);
    dat(8'hA1);
    check(pgWrEn === 1'b1 && pgCol === 10'd526 && pgData === 8'hA1, "R6", pgCol, 526);
    dat(8'hA2);
    check(pgWrEn === 1'b1 && pgCol === 10'd527, "R6", pgCol, 527);
    dat(8'hA3);
    check(pgWrEn === 1'b0, "R6", pgWrEn, 0);
    dat(8'hA4);
    cmd(8'h10);
    check(arrReq === 1'b1 && arrOp === 2'd1 && arrCol === 10'd526, "R6", arrCol, 526);
    dat(8'h55);
    check(pgWrEn === 1'b0, "R10", pgWrEn, 0);
    done(1'b0);
    cmd(8'h70); tick(); rd();
    check(busOut === 8'hC0, "R8", busOut, 8'hC0);
    // R6: area A run crossing into the high half
    cmd(8'h00); cmd(8'h80);
    addr4(8'hFE, 8'h00, 8'h01, 8'h00);
    dat(8'h10); dat(8'h11); dat(8'h12);
    check(pgCol === 10'd256 && pgData === 8'h12, "R6", pgCol, 256);
    cmd(8'h10);
    done(1'b0);

    // R9: reset from ready lasts exactly RST_CYC cycles
    curReq = "R9";
    cmd(8'h01);
    cmd(8'hFF);
    lowCnt = 0;
    while (!rdyBsy && lowCnt < 1000) begin lowCnt++; tick(); end
    check(lowCnt == RST_CYC, "R9", lowCnt, RST_CYC);
    // R3: reset restored area A
    curReq = "R3";
    addr4(8'h09, 8'h00, 8'h00, 8'h00);
    check(arrCol === 10'd9, "R3", arrCol, 9);
    // R9: reset during a pending read withdraws it
    curReq = "R9";
    cmd(8'hFF);
    check(arrReq === 1'b0 && rdyBsy === 1'b0, "R9", arrReq, 0);
    repeat (RST_CYC + 2) tick();
    check(rdyBsy === 1'b1, "R9", rdyBsy, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule